// File: doc/BRIEF.md
# Dual-Channel DAC Double-Buffered Register Front End

This block is the digital side of a two-channel 12-bit voltage-output converter. A host processor with a parallel bus that is either 12 or 8 bits wide writes a sample into one of two staging registers. One global transfer command then copies both staging registers into the two converter registers on the same clock edge, so both outputs move together. A clear command, or reset, forces both converter registers to offset-binary mid-scale, which is the zero-volt code.

Each converter register keeps its three top bits as a 7-wire thermometer code. A segmented ladder drives its eight equal segments from these wires. The nine lower bits are kept in plain binary. For checking, each channel also presents the 12-bit offset-binary code rebuilt from the stored fields. Every control input is sampled on the rising clock edge. An operation takes effect on the edge where its enables are high. The analog ladder, the switches and the amplifiers are not part of this block.

Top module: `dual_dac_frontend`

## Requirements
- R1: A synchronous active-high reset sets both staging registers and both converter registers to 0x800. After reset each channel reads thermometer 7'b0001111, low field 0 and code 0x800.
- R2: When `wide_mode`=1 and `cs`=`wr_in`=1 with `addr`=2'b00, the full 12-bit `bus_data` is stored in the channel A staging register on that edge. With `addr`=2'b01 it is stored in the channel B staging register.
- R3: When `wide_mode`=0, a write loads staging bits [3:0] from `bus_data[11:8]`. Staging bits [11:4] keep their old value.
- R4: A cycle with `cs`=0, or with `wr_in`=0, or with `addr[1]`=1, changes no staging register.
- R5: When `wr_xfer`=1 and `xfer`=1 (with `clr`=0), both converter registers load from their staging registers on the same edge. In every other cycle the converter outputs hold, including cycles that write the staging registers.
- R6: When `wr_xfer`=1 and `clr`=1, both converter registers go to 0x800, whatever `xfer` is. The staging registers are not changed. `clr` has no effect while `wr_xfer`=0.
- R7: Thermometer bit i (i = 0..6) of a channel is 1 exactly when code bits [11:9] exceed i. The low field equals code bits [8:0]. The code output equals {count of ones in the thermometer, low field}.
- R8: If a staging write and a transfer fall on the same edge, the converter register receives the staging value held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset (power-on) |
| bus_data | input | 12 | Host data bus |
| wide_mode | input | 1 | 1 = 12-bit bus, 0 = 8-bit MSB-justified bus |
| addr | input | 2 | Staging register select: 00 = A, 01 = B, others ignored |
| cs | input | 1 | Chip select for staging writes |
| wr_in | input | 1 | Staging write strobe |
| wr_xfer | input | 1 | Strobe qualifying transfer and clear |
| xfer | input | 1 | Transfer both staging registers to converter registers |
| clr | input | 1 | Clear both converter registers to mid-scale |
| dac_a_therm | output | 7 | Channel A top-segment thermometer code |
| dac_a_lsb | output | 9 | Channel A low binary field |
| dac_a_code | output | 12 | Channel A rebuilt offset-binary code |
| dac_b_therm | output | 7 | Channel B top-segment thermometer code |
| dac_b_lsb | output | 9 | Channel B low binary field |
| dac_b_code | output | 12 | Channel B rebuilt offset-binary code |

## Verification
All 4096 codes are written to channel A in wide mode, and at the same time their complements are written to channel B. This separates the two channel selects, catches swapped or stuck bits, and checks every thermometer boundary. An output check between the staging writes and the transfer shows that staging writes never reach the outputs early. All sixteen nibbles are loaded in narrow mode over a fixed upper byte, which shows that the upper bits are protected. Separate patterns cover ignored addresses and strobes, clear against transfer, a transfer with no strobe, and a write and transfer on the same edge.

// File: rtl/dacfe_pkg.sv
package dacfe_pkg;
  localparam int unsigned CODE_W_DEF = 12;
  localparam int unsigned SEG_W_DEF  = 3;
  localparam int unsigned BUS_NARROW_W_DEF = 8;

  typedef struct packed {
    logic load;
    logic clear;
  } dac_cmd_t;
endpackage

// File: rtl/dacfe_ctrl.sv
module dacfe_ctrl
  import dacfe_pkg::*;
#(
  parameter int unsigned NUM_CH = 2,
  parameter int unsigned ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs,
  input  logic              wr_in,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_xfer,
  input  logic              xfer,
  input  logic              clr,
  output logic [NUM_CH-1:0] ch_we,
  output dac_cmd_t          cmd
);
  localparam int unsigned SEL_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  logic addr_ok;
  logic strobe;

  assign addr_ok = ~|addr[ADDR_W-1:SEL_W];
  assign strobe  = cs & wr_in & addr_ok;

  genvar c;
  generate
    for (c = 0; c < NUM_CH; c++) begin : g_we
      assign ch_we[c] = strobe & (addr[SEL_W-1:0] == SEL_W'(c));
    end
  endgenerate

  assign cmd.clear = wr_xfer & clr;
  assign cmd.load  = wr_xfer & xfer & ~clr;

  p_bad_addr_r4: assert property (@(posedge clk) disable iff (rst)
    (addr[ADDR_W-1] || !cs || !wr_in) |-> (ch_we == '0));
  p_clear_wins_r6: assert property (@(posedge clk) disable iff (rst)
    (wr_xfer && clr) |-> (cmd.clear && !cmd.load));
  p_one_target_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ch_we));
endmodule

// File: rtl/dacfe_in_reg.sv
module dacfe_in_reg #(
  parameter int unsigned CODE_W       = 12,
  parameter int unsigned BUS_NARROW_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic              wide,
  input  logic [CODE_W-1:0] bus,
  output logic [CODE_W-1:0] value
);
  localparam int unsigned LOW_W = CODE_W - BUS_NARROW_W;
  localparam logic [CODE_W-1:0] MID = CODE_W'(1) << (CODE_W - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      value <= MID;
    end else if (we) begin
      if (wide) value <= bus;
      else      value[LOW_W-1:0] <= bus[CODE_W-1 -: LOW_W];
    end
  end

  p_narrow_upper_r3: assert property (@(posedge clk) disable iff (rst)
    (we && !wide) |=> (value[CODE_W-1:LOW_W] == $past(value[CODE_W-1:LOW_W])));
  p_narrow_low_r3: assert property (@(posedge clk) disable iff (rst)
    (we && !wide) |=> (value[LOW_W-1:0] == $past(bus[CODE_W-1 -: LOW_W])));
  p_idle_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(value));
endmodule

// File: rtl/dacfe_dac_reg.sv
module dacfe_dac_reg
  import dacfe_pkg::*;
#(
  parameter int unsigned CODE_W = 12,
  parameter int unsigned SEG_W  = 3
) (
  input  logic                       clk,
  input  logic                       rst,
  input  dac_cmd_t                   cmd,
  input  logic [CODE_W-1:0]          in_code,
  output logic [(1<<SEG_W)-2:0]      therm,
  output logic [CODE_W-SEG_W-1:0]    lsb
);
  localparam int unsigned THERM_W = (1 << SEG_W) - 1;
  localparam int unsigned LSB_W   = CODE_W - SEG_W;
  localparam int unsigned MID_SEG = 1 << (SEG_W - 1);

  logic [THERM_W-1:0] therm_d;
  logic [THERM_W-1:0] mid_therm;

  genvar i;
  generate
    for (i = 0; i < THERM_W; i++) begin : g_seg
      assign therm_d[i]   = (int'(in_code[CODE_W-1 -: SEG_W]) > i);
      assign mid_therm[i] = (i < MID_SEG);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst || cmd.clear) begin
      therm <= mid_therm;
      lsb   <= '0;
    end else if (cmd.load) begin
      therm <= therm_d;
      lsb   <= in_code[LSB_W-1:0];
    end
  end

  p_clear_mid_r6: assert property (@(posedge clk) disable iff (rst)
    cmd.clear |=> (lsb == '0 && $countones(therm) == MID_SEG));
  p_load_copies_r5: assert property (@(posedge clk) disable iff (rst)
    (cmd.load && !cmd.clear) |=> (lsb == $past(in_code[LSB_W-1:0])));
  p_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (!cmd.load && !cmd.clear) |=> ($stable(therm) && $stable(lsb)));
  p_therm_shape_r7: assert property (@(posedge clk) disable iff (rst)
    ((therm & (therm + THERM_W'(1))) == '0));
endmodule

// File: rtl/dual_dac_frontend.sv
module dual_dac_frontend
  import dacfe_pkg::*;
#(
  parameter int unsigned CODE_W       = CODE_W_DEF,
  parameter int unsigned SEG_W        = SEG_W_DEF,
  parameter int unsigned BUS_NARROW_W = BUS_NARROW_W_DEF,
  parameter int unsigned ADDR_W       = 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [CODE_W-1:0]          bus_data,
  input  logic                       wide_mode,
  input  logic [ADDR_W-1:0]          addr,
  input  logic                       cs,
  input  logic                       wr_in,
  input  logic                       wr_xfer,
  input  logic                       xfer,
  input  logic                       clr,
  output logic [(1<<SEG_W)-2:0]      dac_a_therm,
  output logic [CODE_W-SEG_W-1:0]    dac_a_lsb,
  output logic [CODE_W-1:0]          dac_a_code,
  output logic [(1<<SEG_W)-2:0]      dac_b_therm,
  output logic [CODE_W-SEG_W-1:0]    dac_b_lsb,
  output logic [CODE_W-1:0]          dac_b_code
);
  localparam int unsigned NUM_CH  = 2;
  localparam int unsigned THERM_W = (1 << SEG_W) - 1;
  localparam int unsigned LSB_W   = CODE_W - SEG_W;

  logic [NUM_CH-1:0]  ch_we;
  dac_cmd_t           cmd;
  logic [CODE_W-1:0]  stage_q [NUM_CH];
  logic [THERM_W-1:0] therm_q [NUM_CH];
  logic [LSB_W-1:0]   lsb_q   [NUM_CH];
  logic [SEG_W-1:0]   seg_cnt [NUM_CH];

  dacfe_ctrl #(
    .NUM_CH (NUM_CH),
    .ADDR_W (ADDR_W)
  ) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .cs      (cs),
    .wr_in   (wr_in),
    .addr    (addr),
    .wr_xfer (wr_xfer),
    .xfer    (xfer),
    .clr     (clr),
    .ch_we   (ch_we),
    .cmd     (cmd)
  );

  genvar c;
  generate
    for (c = 0; c < NUM_CH; c++) begin : g_ch
      dacfe_in_reg #(
        .CODE_W       (CODE_W),
        .BUS_NARROW_W (BUS_NARROW_W)
      ) u_in (
        .clk   (clk),
        .rst   (rst),
        .we    (ch_we[c]),
        .wide  (wide_mode),
        .bus   (bus_data),
        .value (stage_q[c])
      );

      dacfe_dac_reg #(
        .CODE_W (CODE_W),
        .SEG_W  (SEG_W)
      ) u_dac (
        .clk     (clk),
        .rst     (rst),
        .cmd     (cmd),
        .in_code (stage_q[c]),
        .therm   (therm_q[c]),
        .lsb     (lsb_q[c])
      );

      always_comb begin
        seg_cnt[c] = '0;
        for (int k = 0; k < THERM_W; k++) begin
          seg_cnt[c] = seg_cnt[c] + SEG_W'(therm_q[c][k]);
        end
      end
    end
  endgenerate

  assign dac_a_therm = therm_q[0];
  assign dac_a_lsb   = lsb_q[0];
  assign dac_a_code  = {seg_cnt[0], lsb_q[0]};
  assign dac_b_therm = therm_q[1];
  assign dac_b_lsb   = lsb_q[1];
  assign dac_b_code  = {seg_cnt[1], lsb_q[1]};

  p_joint_update_r5: assert property (@(posedge clk) disable iff (rst)
    $changed(dac_a_code) |-> $past(cmd.load || cmd.clear));
  p_ab_together_r5: assert property (@(posedge clk) disable iff (rst)
    $changed(dac_b_code) |-> $past(cmd.load || cmd.clear));
endmodule

// File: tb/dual_dac_frontend_tb.sv
`timescale 1ns/1ps
module dual_dac_frontend_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic [11:0] bus_data;
  logic        wide_mode;
  logic [1:0]  addr;
  logic        cs, wr_in, wr_xfer, xfer, clr;
  logic [6:0]  a_therm, b_therm;
  logic [8:0]  a_lsb, b_lsb;
  logic [11:0] a_code, b_code;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dual_dac_frontend u_dut (
    .clk (clk), .rst (rst), .bus_data (bus_data), .wide_mode (wide_mode),
    .addr (addr), .cs (cs), .wr_in (wr_in), .wr_xfer (wr_xfer),
    .xfer (xfer), .clr (clr),
    .dac_a_therm (a_therm), .dac_a_lsb (a_lsb), .dac_a_code (a_code),
    .dac_b_therm (b_therm), .dac_b_lsb (b_lsb), .dac_b_code (b_code)
  );

  task automatic idle();
    cs = 0; wr_in = 0; wr_xfer = 0; xfer = 0; clr = 0;
    addr = 2'b00; wide_mode = 1'b1; bus_data = 12'h000;
  endtask

  // One clock cycle with the given controls, driven at the falling edge.
  task automatic step(input logic s_cs, input logic s_wr, input logic [1:0] s_addr,
                      input logic [11:0] s_bus, input logic s_wide,
                      input logic s_wx, input logic s_xf, input logic s_clr);
    @(negedge clk);
    cs = s_cs; wr_in = s_wr; addr = s_addr; bus_data = s_bus; wide_mode = s_wide;
    wr_xfer = s_wx; xfer = s_xf; clr = s_clr;
    @(negedge clk);
    idle();
  endtask

  task automatic wr(input logic [1:0] a, input logic [11:0] d, input logic w);
    step(1, 1, a, d, w, 0, 0, 0);
  endtask

  task automatic go();
    step(0, 0, 2'b00, 12'h000, 1, 1, 1, 0);
  endtask

  task automatic chk(input int ch, input logic [11:0] e, input string tag);
    logic [6:0] et;
    logic [6:0] gt;
    logic [8:0] gl;
    logic [11:0] gc;
    for (int i = 0; i < 7; i++) et[i] = (int'(e[11:9]) > i);
    gt = (ch == 0) ? a_therm : b_therm;
    gl = (ch == 0) ? a_lsb : b_lsb;
    gc = (ch == 0) ? a_code : b_code;
    n_chk++;
    if (gt !== et || gl !== e[8:0] || gc !== e) begin
      n_fail++;
      $display("FAIL %s ch%0d: therm=%b lsb=%h code=%h expected therm=%b lsb=%h code=%h",
               tag, ch, gt, gl, gc, et, e[8:0], e);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [11:0] ea, eb;
    idle();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state of converter registers
    chk(0, 12'h800, "R1 reset A");
    chk(1, 12'h800, "R1 reset B");
    // R1: staging registers also reset to mid-scale
    go();
    chk(0, 12'h800, "R1 staging reset A");
    chk(1, 12'h800, "R1 staging reset B");

    // R2, R5, R7: full sweep of codes, complement on B
    ea = 12'h800; eb = 12'h800;
    for (int v = 0; v < 4096; v++) begin
      wr(2'b00, 12'(v), 1);
      wr(2'b01, ~12'(v), 1);
      if (v % 64 == 0) begin
        chk(0, ea, "R5 hold before transfer A");
        chk(1, eb, "R5 hold before transfer B");
      end
      go();
      ea = 12'(v); eb = ~12'(v);
      chk(0, ea, "R2 R7 wide write A");
      chk(1, eb, "R2 R7 wide write B");
    end

    // R3: narrow mode loads low nibble from upper bus lines
    wr(2'b00, 12'h5A3, 1);
    wr(2'b01, 12'hC3C, 1);
    for (int n = 0; n < 16; n++) begin
      wr(2'b00, {4'(n), 8'hC3}, 0);
      wr(2'b01, {4'(15 - n), 8'h3C}, 0);
      go();
      chk(0, {8'h5A, 4'(n)}, "R3 narrow A");
      chk(1, {8'hC3, 4'(15 - n)}, "R3 narrow B");
    end
    ea = {8'h5A, 4'hF}; eb = {8'hC3, 4'h0};

    // R4: ignored addresses and strobes
    step(1, 1, 2'b10, 12'h111, 1, 0, 0, 0);
    step(1, 1, 2'b11, 12'h222, 1, 0, 0, 0);
    step(0, 1, 2'b00, 12'h333, 1, 0, 0, 0);
    step(1, 0, 2'b01, 12'h444, 1, 0, 0, 0);
    go();
    chk(0, ea, "R4 ignored writes A");
    chk(1, eb, "R4 ignored writes B");

    // R5: transfer without strobe, strobe without transfer
    wr(2'b00, 12'h0F0, 1);
    wr(2'b01, 12'hF0F, 1);
    step(0, 0, 2'b00, 12'h000, 1, 0, 1, 0);
    chk(0, ea, "R5 xfer no strobe A");
    step(0, 0, 2'b00, 12'h000, 1, 1, 0, 0);
    chk(1, eb, "R5 strobe no xfer B");
    go();
    chk(0, 12'h0F0, "R5 joint load A");
    chk(1, 12'hF0F, "R5 joint load B");

    // R6: clear without strobe ignored, clear beats transfer, staging kept
    wr(2'b00, 12'hABC, 1);
    wr(2'b01, 12'h123, 1);
    step(0, 0, 2'b00, 12'h000, 1, 0, 1, 1);
    chk(0, 12'h0F0, "R6 clr no strobe A");
    step(0, 0, 2'b00, 12'h000, 1, 1, 1, 1);
    chk(0, 12'h800, "R6 clear wins A");
    chk(1, 12'h800, "R6 clear wins B");
    go();
    chk(0, 12'hABC, "R6 staging kept A");
    chk(1, 12'h123, "R6 staging kept B");
    step(0, 0, 2'b00, 12'h000, 1, 1, 0, 1);
    chk(0, 12'h800, "R6 plain clear A");
    chk(1, 12'h800, "R6 plain clear B");

    // R8: write and transfer on the same edge
    step(1, 1, 2'b00, 12'h777, 1, 1, 1, 0);
    chk(0, 12'hABC, "R8 same-edge old value A");
    chk(1, 12'h123, "R8 same-edge B");
    go();
    chk(0, 12'h777, "R8 new value next transfer A");

    // R1: reset from a non-mid state
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(0, 12'h800, "R1 re-reset A");
    chk(1, 12'h800, "R1 re-reset B");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule